// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block owns the control bits of an analog PLL (reset release, bypass, lock-source select) and writes its two divider words whenever a new frequency setting is requested. A request carries a feedback multiplier m, a pre-divider p, a post-divider s and a 16-bit fraction k, plus a flag saying whether the PLL runs in integer or fractional mode. The sequencer compares the requested m and p with the divider word that is currently programmed, which it receives on an input. When they match, the PLL stays locked and only the post-divider (and the fraction in fractional mode) is rewritten in a single cycle. When they differ, it runs a full relock. In integer mode it first selects the PLL output as the lock source. It then holds the PLL in reset, switches the output to bypass and writes the new divider words. After a settle time it releases reset, waits for lock and finally leaves bypass.

The same engine also handles power-up and power-down requests. All delays are counted on the free-running clock, with lengths derived from a clock-frequency parameter and rounded up to whole cycles. While a sequence is running the block reports busy, and any request that arrives in that time is dropped.

Top module: `pll_relock_seq`

## Requirements
- R1: After reset, the reset-release, bypass and lock-select outputs are 0, busy and done are 0, and neither divider write strobe is active.
- R2: The first divider word holds m in bits 21:12, p in bits 9:4 and s in bits 2:0. The second word holds k in bits 15:0 with the upper bits 0. On a full relock the first word is written with all other bits 0, and the second word is written only in fractional mode (cmd_frac = 1).
- R3: A rate request (cmd_op = 0) whose m and p equal bits 21:12 and 9:4 of cur_div0 writes, one cycle after acceptance, cur_div0 with bits 2:0 replaced by s. In fractional mode it also writes the second word. It pulses done in the same cycle and leaves reset-release, bypass and lock-select unchanged.
- R4: Otherwise the full sequence clears reset-release in the second cycle after acceptance, sets bypass in the third and writes the divider words in the fourth, one step per cycle.
- R5: In integer mode lock-select is set in the first cycle after acceptance, before reset is asserted. In fractional mode it is left unchanged.
- R6: Reset-release rises exactly SETTLE_CYC = ceil(SETTLE_NS × CLK_MHZ / 1000) cycles after the cycle in which the divider words were written.
- R7: If lock is seen within the window, the cycle after lock is sampled clears bypass and pulses done with err_o = 0.
- R8: If lock is not seen in the LOCK_CYC = LOCK_US × CLK_MHZ cycles after release, done and err_o pulse together at the end of that window, with bypass and reset-release both left at 1. A lock sampled on the last cycle of the window still counts as success.
- R9: Power-up (cmd_op = 1) with reset-release already 1 only pulses done one cycle after acceptance. Otherwise it sets bypass, sets reset-release one cycle later, and then completes as in R7 and R8.
- R10: Power-down (cmd_op = 2) clears reset-release and pulses done one cycle after acceptance.
- R11: busy is 1 from the cycle after a multi-cycle sequence is accepted until done. Requests during busy, and cmd_op = 3 at any time, are ignored without being queued, and each accepted request yields exactly one done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock of CLK_MHZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Request strobe, taken when not busy |
| cmd_op | input | 2 | 0 rate, 1 power-up, 2 power-down, 3 no-op |
| cmd_frac | input | 1 | 1 = fractional mode, 0 = integer mode |
| cmd_m | input | 10 | Requested multiplier |
| cmd_p | input | 6 | Requested pre-divider |
| cmd_s | input | 3 | Requested post-divider |
| cmd_k | input | 16 | Requested fraction |
| cur_div0 | input | 32 | Currently programmed first divider word |
| pll_lock | input | 1 | Lock indication from the PLL |
| busy_o | output | 1 | Sequence in progress |
| ctl_rst_rel_o | output | 1 | Reset release (0 holds the PLL in reset) |
| ctl_bypass_o | output | 1 | Bypass the PLL output |
| ctl_lock_sel_o | output | 1 | Lock source select |
| div0_wdata_o | output | 32 | First divider word write value |
| div0_we_o | output | 1 | First divider word write strobe |
| div1_wdata_o | output | 32 | Second divider word write value |
| div1_we_o | output | 1 | Second divider word write strobe |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Lock timeout, valid with done |

## Verification
Rate requests are issued with m and p copied from the programmed word, to drive the one-cycle path, and with fresh random values, to drive the relock path. Each kind is tried in both integer and fractional mode, which shows whether the path choice, the word layout and the lock-select handling follow the requested mode. Lock delays are drawn at random and also set to exactly one cycle inside and one cycle outside the timeout window, to separate success from timeout at the boundary. Power-up from both the off and the running state, power-down, the no-op code and a request injected while busy show that only accepted requests change the control bits.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    localparam int M_W   = 10;
    localparam int P_W   = 6;
    localparam int S_W   = 3;
    localparam int K_W   = 16;
    localparam int W_W   = 32;
    localparam int M_LSB = 12;
    localparam int P_LSB = 4;
    localparam int S_LSB = 0;

    typedef enum logic [1:0] {
        OP_RATE   = 2'd0,
        OP_PWR_UP = 2'd1,
        OP_PWR_DN = 2'd2,
        OP_NONE   = 2'd3
    } seq_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_ON,
        ST_BYP_ON,
        ST_PROG,
        ST_SETTLE,
        ST_PU_REL,
        ST_LOCKWAIT
    } seq_state_e;

    typedef struct packed {
        seq_state_e       state;
        logic             rst_rel;
        logic             bypass;
        logic             lock_sel;
        logic             frac;
        logic [M_W-1:0]   m;
        logic [P_W-1:0]   p;
        logic [S_W-1:0]   s;
        logic [K_W-1:0]   k;
        logic [W_W-1:0]   div0;
        logic             div0_we;
        logic [W_W-1:0]   div1;
        logic             div1_we;
        logic             done;
        logic             err;
    } seq_regs_t;

    function automatic logic [W_W-1:0] build_div0(
        input logic [M_W-1:0] m,
        input logic [P_W-1:0] p,
        input logic [S_W-1:0] s
    );
        logic [W_W-1:0] w;
        w = '0;
        w[M_LSB +: M_W] = m;
        w[P_LSB +: P_W] = p;
        w[S_LSB +: S_W] = s;
        return w;
    endfunction

endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
    parameter int TW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/pll_seq_match.sv
module pll_seq_match
    import pll_seq_pkg::*;
(
    input  logic [W_W-1:0] cur_div0,
    input  logic [M_W-1:0] req_m,
    input  logic [P_W-1:0] req_p,
    input  logic [S_W-1:0] req_s,
    output logic           mp_same,
    output logic [W_W-1:0] fast_word
);
    always_comb begin
        mp_same   = (cur_div0[M_LSB +: M_W] == req_m) &&
                    (cur_div0[P_LSB +: P_W] == req_p);
        fast_word = cur_div0;
        fast_word[S_LSB +: S_W] = req_s;
    end
endmodule

// File: rtl/pll_relock_seq.sv
module pll_relock_seq
    import pll_seq_pkg::*;
#(
    parameter int CLK_MHZ   = 100,
    parameter int SETTLE_NS = 3000,
    parameter int LOCK_US   = 10000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic             cmd_frac,
    input  logic [M_W-1:0]   cmd_m,
    input  logic [P_W-1:0]   cmd_p,
    input  logic [S_W-1:0]   cmd_s,
    input  logic [K_W-1:0]   cmd_k,
    input  logic [W_W-1:0]   cur_div0,
    input  logic             pll_lock,
    output logic             busy_o,
    output logic             ctl_rst_rel_o,
    output logic             ctl_bypass_o,
    output logic             ctl_lock_sel_o,
    output logic [W_W-1:0]   div0_wdata_o,
    output logic             div0_we_o,
    output logic [W_W-1:0]   div1_wdata_o,
    output logic             div1_we_o,
    output logic             done_o,
    output logic             err_o
);
    localparam int SETTLE_RAW = (SETTLE_NS * CLK_MHZ + 999) / 1000;
    localparam int SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;
    localparam int LOCK_RAW   = LOCK_US * CLK_MHZ;
    localparam int LOCK_CYC   = (LOCK_RAW < 1) ? 1 : LOCK_RAW;
    localparam int TMAX       = (SETTLE_CYC > LOCK_CYC) ? SETTLE_CYC : LOCK_CYC;
    localparam int TW         = $clog2(TMAX + 1);
    localparam int SW         = $clog2(SETTLE_CYC + 1);

    seq_regs_t      d, q;
    logic           mp_same;
    logic [W_W-1:0] fast_word;
    logic           tmr_load, tmr_zero;
    logic [TW-1:0]  tmr_val;

    pll_seq_match u_match (
        .cur_div0  (cur_div0),
        .req_m     (cmd_m),
        .req_p     (cmd_p),
        .req_s     (cmd_s),
        .mp_same   (mp_same),
        .fast_word (fast_word)
    );

    pll_seq_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    always_comb begin
        d         = q;
        d.div0_we = 1'b0;
        d.div1_we = 1'b0;
        d.done    = 1'b0;
        d.err     = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        case (q.state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    case (seq_op_e'(cmd_op))
                        OP_RATE: begin
                            d.m    = cmd_m;
                            d.p    = cmd_p;
                            d.s    = cmd_s;
                            d.k    = cmd_k;
                            d.frac = cmd_frac;
                            if (mp_same) begin
                                d.div0    = fast_word;
                                d.div0_we = 1'b1;
                                d.div1    = {{(W_W-K_W){1'b0}}, cmd_k};
                                d.div1_we = cmd_frac;
                                d.done    = 1'b1;
                            end else begin
                                if (!cmd_frac) d.lock_sel = 1'b1;
                                d.state = ST_RST_ON;
                            end
                        end
                        OP_PWR_UP: begin
                            if (q.rst_rel) begin
                                d.done = 1'b1;
                            end else begin
                                d.bypass = 1'b1;
                                d.state  = ST_PU_REL;
                            end
                        end
                        OP_PWR_DN: begin
                            d.rst_rel = 1'b0;
                            d.done    = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            ST_RST_ON: begin
                d.rst_rel = 1'b0;
                d.state   = ST_BYP_ON;
            end
            ST_BYP_ON: begin
                d.bypass = 1'b1;
                d.state  = ST_PROG;
            end
            ST_PROG: begin
                d.div0    = build_div0(q.m, q.p, q.s);
                d.div0_we = 1'b1;
                d.div1    = {{(W_W-K_W){1'b0}}, q.k};
                d.div1_we = q.frac;
                tmr_load  = 1'b1;
                tmr_val   = TW'(SETTLE_CYC - 1);
                d.state   = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (tmr_zero) begin
                    d.rst_rel = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = TW'(LOCK_CYC - 1);
                    d.state   = ST_LOCKWAIT;
                end
            end
            ST_PU_REL: begin
                d.rst_rel = 1'b1;
                tmr_load  = 1'b1;
                tmr_val   = TW'(LOCK_CYC - 1);
                d.state   = ST_LOCKWAIT;
            end
            ST_LOCKWAIT: begin
                if (pll_lock) begin
                    d.bypass = 1'b0;
                    d.done   = 1'b1;
                    d.state  = ST_IDLE;
                end else if (tmr_zero) begin
                    d.done  = 1'b1;
                    d.err   = 1'b1;
                    d.state = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy_o         = (q.state != ST_IDLE);
    assign ctl_rst_rel_o  = q.rst_rel;
    assign ctl_bypass_o   = q.bypass;
    assign ctl_lock_sel_o = q.lock_sel;
    assign div0_wdata_o   = q.div0;
    assign div0_we_o      = q.div0_we;
    assign div1_wdata_o   = q.div1;
    assign div1_we_o      = q.div1_we;
    assign done_o         = q.done;
    assign err_o          = q.err;

    // cycles since the last divider write, saturating at the settle length
    logic [SW-1:0] since_wr_d, since_wr_q;
    always_comb begin
        since_wr_d = since_wr_q;
        if (div0_we_o)                                since_wr_d = '0;
        else if (since_wr_q < SW'(SETTLE_CYC))        since_wr_d = since_wr_q + 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) since_wr_q <= '0;
        else        since_wr_q <= since_wr_d;
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |-> (!ctl_rst_rel_o && !ctl_bypass_o && !done_o)) else $error("reset state"); // R1
    AST_BYP_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_bypass_o) |-> !ctl_rst_rel_o) else $error("bypass order"); // R4
    AST_LSEL_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ctl_rst_rel_o) && busy_o && !q.frac) |-> $past(ctl_lock_sel_o)) else $error("lock select order"); // R5
    AST_SETTLE_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ctl_rst_rel_o) && $past(q.state) == ST_SETTLE) |-> (since_wr_q >= SW'(SETTLE_CYC - 1))) else $error("settle too short"); // R6
    AST_BYP_DROP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_bypass_o) |-> $past(pll_lock)) else $error("bypass left unlocked"); // R7
    AST_TIMEOUT_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (done_o && ctl_bypass_o && ctl_rst_rel_o)) else $error("timeout state"); // R8
    AST_FAST_KEEPS_CTL: assert property (@(posedge clk) disable iff (!rst_n)
        (div0_we_o && !busy_o) |-> ($stable(ctl_rst_rel_o) && $stable(ctl_bypass_o) && $stable(ctl_lock_sel_o))) else $error("fast path touched control"); // R3
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o) else $error("done while busy"); // R11
endmodule

// File: tb/pll_relock_seq_bench.sv
module pll_relock_seq_bench;
    localparam int CLK_MHZ = 100;
    localparam int S_CYC   = 300;   // 3000 ns at 100 MHz
    localparam int L_CYC   = 500;   // 5 us at 100 MHz

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd3;
    logic        cmd_frac = 1'b0;
    logic [9:0]  cmd_m = '0;
    logic [5:0]  cmd_p = '0;
    logic [2:0]  cmd_s = '0;
    logic [15:0] cmd_k = '0;
    logic [31:0] cur_div = '0;
    logic        pll_lock = 1'b0;
    logic        busy_o, rst_rel_o, bypass_o, lock_sel_o, div0_we_o, div1_we_o, done_o, err_o;
    logic [31:0] div0_wdata_o, div1_wdata_o;

    int total = 0;
    int bad = 0;
    int lock_dly = 0;
    int lock_cnt = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pll_relock_seq #(.CLK_MHZ(CLK_MHZ), .SETTLE_NS(3000), .LOCK_US(5)) u_pll_relock_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_frac(cmd_frac), .cmd_m(cmd_m), .cmd_p(cmd_p), .cmd_s(cmd_s),
        .cmd_k(cmd_k), .cur_div0(cur_div), .pll_lock(pll_lock),
        .busy_o(busy_o), .ctl_rst_rel_o(rst_rel_o), .ctl_bypass_o(bypass_o),
        .ctl_lock_sel_o(lock_sel_o), .div0_wdata_o(div0_wdata_o), .div0_we_o(div0_we_o),
        .div1_wdata_o(div1_wdata_o), .div1_we_o(div1_we_o), .done_o(done_o), .err_o(err_o)
    );

    // analog PLL model and divider register
    always @(posedge clk) begin
        if (!rst_rel_o) begin
            lock_cnt <= 0;
            pll_lock <= 1'b0;
        end else if (lock_cnt == lock_dly) begin
            pll_lock <= 1'b1;
        end else if (lock_cnt < 1000000) begin
            lock_cnt <= lock_cnt + 1;
        end
        if (div0_we_o) cur_div <= div0_wdata_o;
    end

    function automatic logic [31:0] exp_full(input logic [9:0] m, input logic [5:0] p, input logic [2:0] s);
        return (32'(m) << 12) | (32'(p) << 4) | 32'(s);
    endfunction

    function automatic logic [31:0] exp_fast(input logic [31:0] cur, input logic [2:0] s);
        return (cur & ~32'h7) | 32'(s);
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic lock_phase(input int t_rel, input int t_done, input int dly,
                              input logic e, input logic b, input logic r);
        if (dly <= L_CYC - 2) begin
            chk(t_done == t_rel + dly + 2, "R7 done timing", t_done, t_rel + dly + 2);
            chk(!e && !b && r, "R7 end state err/byp/rst", {e, b, r}, 3'b001);
        end else begin
            chk(t_done == t_rel + L_CYC, "R8 timeout timing", t_done, t_rel + L_CYC);
            chk(e && b && r, "R8 end state err/byp/rst", {e, b, r}, 3'b111);
        end
    endtask

    task automatic run_cmd(input int op, input logic [9:0] m, input logic [5:0] p,
                           input logic [2:0] s, input logic [15:0] k, input logic frac,
                           input int dly, input int inj_t);
        int t_wr, t_rel, t_done, ndone, n1;
        logic [31:0] w0, w1, cur0;
        logic err_at, byp_at, rst_at, lsel1, rst1, rst2, byp1, byp2, byp3, busy1;
        logic rst0, byp0, lsel0, prev_rst, fast;
        t_wr = -1; t_rel = -1; t_done = -1; ndone = 0; n1 = 0;
        w0 = '0; w1 = '0; err_at = 0; byp_at = 0; rst_at = 0;
        lsel1 = 0; rst1 = 0; rst2 = 0; byp1 = 0; byp2 = 0; byp3 = 0; busy1 = 0;
        @(negedge clk);
        lock_dly = dly;
        cur0 = cur_div; rst0 = rst_rel_o; byp0 = bypass_o; lsel0 = lock_sel_o;
        prev_rst = rst0;
        fast = (m == cur0[21:12]) && (p == cur0[9:4]);
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_m = m; cmd_p = p; cmd_s = s;
        cmd_k = k; cmd_frac = frac;
        for (int t = 1; t <= 2000; t++) begin
            @(negedge clk);
            if (div0_we_o && t_wr < 0) begin t_wr = t; w0 = div0_wdata_o; end
            if (div1_we_o) begin n1++; w1 = div1_wdata_o; end
            if (done_o) begin
                ndone++;
                if (t_done < 0) begin
                    t_done = t; err_at = err_o; byp_at = bypass_o; rst_at = rst_rel_o;
                end
            end
            if (rst_rel_o && !prev_rst && t_rel < 0) t_rel = t;
            prev_rst = rst_rel_o;
            if (t == 1) begin lsel1 = lock_sel_o; rst1 = rst_rel_o; byp1 = bypass_o; busy1 = busy_o; end
            if (t == 2) begin rst2 = rst_rel_o; byp2 = bypass_o; end
            if (t == 3) byp3 = bypass_o;
            cmd_valid = (t == inj_t);
            if (t == inj_t) cmd_op = 2'd2;
            if (t_done > 0 && t >= t_done + 3) break;
            if (op == 3 && t >= 8) break;
        end
        case (op)
            0: if (fast) begin
                chk(t_wr == 1, "R3 fast write cycle", t_wr, 1);
                chk(w0 == exp_fast(cur0, s), "R3 fast word", w0, exp_fast(cur0, s));
                chk(n1 == int'(frac), "R3 fraction strobe", n1, frac);
                if (frac) chk(w1 == {16'h0, k}, "R2 fraction word", w1, {16'h0, k});
                chk(t_done == 1, "R3 fast done", t_done, 1);
                chk(rst_rel_o == rst0 && bypass_o == byp0 && lock_sel_o == lsel0,
                    "R3 control kept", {rst_rel_o, bypass_o, lock_sel_o}, {rst0, byp0, lsel0});
            end else begin
                chk(busy1, "R11 busy during relock", busy1, 1);
                if (!frac) chk(lsel1, "R5 lock select first", lsel1, 1);
                else       chk(lsel1 == lsel0, "R5 frac keeps lock select", lsel1, lsel0);
                chk(rst1 == rst0 && rst2 == 0, "R4 reset in second cycle", {rst1, rst2}, {rst0, 1'b0});
                chk(byp2 == byp0 && byp3, "R4 bypass in third cycle", {byp2, byp3}, {byp0, 1'b1});
                chk(t_wr == 4, "R4 write in fourth cycle", t_wr, 4);
                chk(w0 == exp_full(m, p, s), "R2 full word", w0, exp_full(m, p, s));
                chk(n1 == int'(frac) && (!frac || w1 == {16'h0, k}), "R2 second word", w1, {16'h0, k});
                chk(t_rel - t_wr == S_CYC, "R6 settle length", t_rel - t_wr, S_CYC);
                lock_phase(t_rel, t_done, dly, err_at, byp_at, rst_at);
            end
            1: if (rst0) begin
                chk(t_done == 1 && bypass_o == byp0 && rst_rel_o, "R9 power-up skipped", t_done, 1);
            end else begin
                chk(byp1 && !rst1, "R9 bypass before release", {byp1, rst1}, 2'b10);
                chk(t_rel == 2, "R9 release cycle", t_rel, 2);
                lock_phase(t_rel, t_done, dly, err_at, byp_at, rst_at);
            end
            2: begin
                chk(t_done == 1 && !rst_at, "R10 power-down", {t_done, rst_at}, {1, 1'b0});
                chk(bypass_o == byp0, "R10 bypass untouched", bypass_o, byp0);
            end
            default: begin
                chk(ndone == 0 && t_wr < 0, "R11 no-op ignored", ndone, 0);
                chk(rst_rel_o == rst0 && bypass_o == byp0 && lock_sel_o == lsel0,
                    "R11 no-op control kept", {rst_rel_o, bypass_o, lock_sel_o}, {rst0, byp0, lsel0});
            end
        endcase
        if (op != 3) chk(ndone == 1, "R11 one done per request", ndone, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5eed));
        repeat (3) @(negedge clk);
        chk(!rst_rel_o && !bypass_o && !lock_sel_o && !busy_o && !done_o && !div0_we_o && !div1_we_o,
            "R1 reset outputs", {rst_rel_o, bypass_o, lock_sel_o, busy_o, done_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rst_rel_o && !bypass_o && !busy_o, "R1 after release", {rst_rel_o, bypass_o, busy_o}, 0);

        run_cmd(3, 0, 0, 0, 0, 0, 0, 0);                          // no-op
        run_cmd(1, 0, 0, 0, 0, 0, 20, 0);                         // power-up from off
        run_cmd(1, 0, 0, 0, 0, 0, 20, 0);                         // already running
        run_cmd(0, 10'd225, 6'd3, 3'd1, 16'h0, 0, 15, 0);         // integer relock
        run_cmd(0, 10'd225, 6'd3, 3'd2, 16'h0, 0, 15, 0);         // integer fast path
        run_cmd(0, 10'd225, 6'd3, 3'd3, 16'h2d4a, 1, 15, 0);      // fractional fast path
        run_cmd(0, 10'd173, 6'd2, 3'd1, 16'h4000, 1, 30, 0);      // fractional relock
        run_cmd(0, 10'd300, 6'd3, 3'd1, 16'h0, 0, L_CYC - 2, 0);  // last lock cycle
        run_cmd(0, 10'd301, 6'd3, 3'd1, 16'h0, 0, L_CYC - 1, 0);  // just too late
        run_cmd(0, 10'd302, 6'd5, 3'd0, 16'h0, 0, 40, S_CYC + 10);// request during busy
        run_cmd(2, 0, 0, 0, 0, 0, 0, 0);                          // power-down
        run_cmd(1, 0, 0, 0, 0, 0, 5, 0);

        for (int i = 0; i < 24; i++) begin
            int op_sel, dly;
            logic [9:0] m;
            logic [5:0] p;
            op_sel = int'($urandom_range(0, 9));
            dly    = int'($urandom_range(0, 60));
            if (op_sel == 9) dly = 800;
            if ($urandom_range(0, 1) == 1) begin
                m = cur_div[21:12];
                p = cur_div[9:4];
            end else begin
                m = 10'($urandom_range(1, 1023));
                p = 6'($urandom_range(1, 63));
            end
            if (op_sel == 7)      run_cmd(1, 0, 0, 0, 0, 0, dly, 0);
            else if (op_sel == 8) run_cmd(2, 0, 0, 0, 0, 0, dly, 0);
            else run_cmd(0, m, p, 3'($urandom_range(0, 7)), 16'($urandom),
                         1'($urandom_range(0, 1)), dly, 0);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule